// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sticky Read-Cleared Flags

This block recovers 8N1 asynchronous serial characters (one start bit, eight data bits, one stop bit, no parity) from a single receive line. A second clock, running at sixteen times the baud rate (9600 baud nominal), drives the bit engine. The line is first passed through a two-flop synchronizer. The engine then looks for a high-to-low transition and confirms the start bit at its middle. It shifts in eight data bits, least significant bit first, and judges the stop bit.

The engine runs in three named states. **IDLE** waits for a line fall. **START** counts half a bit and checks that the line is still low. **RECV** samples one bit every sixteen oversampling clocks: eight data bits, then the stop bit. The transitions are:
- IDLE→START on a detected fall.
- START→RECV when the mid-bit sample is low.
- START→IDLE when the mid-bit sample is high, which is a false start.
- RECV→IDLE once the stop sample has been taken.

On a good stop bit the engine pulses a valid strobe. On a bad stop bit it pulses an error strobe instead.

The CPU-clock side synchronizes both strobes and reacts to their falling edges. A valid fall loads the byte into the receive buffer and sets a full flag. An error fall sets a framing-error flag and leaves the buffer alone. Each flag stays set until the CPU reads its own register: the buffer read clears the full flag, and the status read clears the error flag. A receiver-idle output is high exactly while the engine sits in IDLE.

Top module: `uart_rx_sticky`

## Requirements
- R1: After reset, rx_idle is 1, buf_full is 0, frame_err is 0 and rx_byte is 0x00.
- R2: A falling edge on rx_line while idle moves the engine to START, and rx_idle goes low.
- R3: If rx_line is high at the START check (8 oversampling clocks after the detected fall), the engine returns to IDLE and neither flag is set.
- R4: The eight data bits are sampled 16 oversampling clocks apart, starting 16 clocks after the start check, and are assembled with the first bit received in bit 0 of rx_byte.
- R5: A stop sample of 1 loads the received byte into rx_byte and sets buf_full.
- R6: A stop sample of 0 sets frame_err, and leaves both rx_byte and buf_full unchanged.
- R7: buf_full stays set until a cycle with rd_buf high, which clears it on the next cpu_clk edge; rd_stat has no effect on buf_full.
- R8: frame_err stays set until a cycle with rd_stat high, which clears it on the next cpu_clk edge; rd_buf has no effect on frame_err.
- R9: When a flag's set event and its clearing read fall in the same cpu_clk cycle, the set wins and the flag reads 1 for that cycle.
- R10: A good frame that arrives while buf_full is already set overwrites rx_byte with the new byte, and buf_full stays 1.
- R11: rx_idle is high exactly while the engine is in IDLE, and it is high again once the stop sample of a frame has been taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_clk | input | 1 | CPU-side clock; flags and buffer live here |
| os_clk | input | 1 | Oversampling clock, 16x the baud rate |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| rx_line | input | 1 | Serial receive line; idles high |
| rd_buf | input | 1 | One-cycle strobe: the CPU reads the receive buffer |
| rd_stat | input | 1 | One-cycle strobe: the CPU reads the status register |
| rx_byte | output | 8 | Receive buffer contents |
| buf_full | output | 1 | Sticky flag: a new byte is in the buffer |
| frame_err | output | 1 | Sticky flag: the last frame had a bad stop bit |
| rx_idle | output | 1 | High while the engine is in IDLE (oversampling domain) |

## Verification
Two functions can fall in the same cpu_clk cycle: a flag being set by a strobe fall, and the same flag being cleared by its register read.

The bench provokes this by holding the matching read strobe high for the whole arrival of a frame. rd_buf is held through a good frame, and rd_stat through a bad-stop frame. The flag is then expected to read 1 for exactly one sampled cycle and to drop on the next one. In the good-frame case, the buffer must already hold the new byte.

A scoreboard carries the ordinary frames. It pushes the expected byte or error per frame, and a monitor pops and compares these whenever a flag rises. The monitor also issues the non-matching read first, to show that it leaves the flag untouched.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_RECV  = 2'd2
    } rx_state_e;

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_engine.sv
module rx_engine
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16,
    parameter int SYNC_N = 2
) (
    input  logic              os_clk,
    input  logic              rst_n,
    input  logic              rx_line,
    output logic [DATA_W-1:0] shift_q,
    output logic              valid_strb,
    output logic              err_strb,
    output logic              rx_idle
);
    localparam int CNT_W  = $clog2(OSR);
    localparam int BIT_W  = $clog2(DATA_W + 1);
    localparam int HALF   = OSR / 2;
    localparam logic [CNT_W-1:0] HALF_END = CNT_W'(HALF - 1);
    localparam logic [CNT_W-1:0] FULL_END = CNT_W'(OSR - 1);
    localparam logic [BIT_W-1:0] STOP_IDX = BIT_W'(DATA_W);

    rx_state_e        state_q, state_d;
    logic             line_s, line_prev;
    logic             line_fall;
    logic [CNT_W-1:0] cnt_q;
    logic [BIT_W-1:0] bit_q;
    logic             half_hit, full_hit;

    rx_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_line_sync (
        .clk   (os_clk),
        .rst_n (rst_n),
        .d     (rx_line),
        .q     (line_s)
    );

    always_ff @(posedge os_clk or negedge rst_n) begin
        if (!rst_n) line_prev <= 1'b1;
        else        line_prev <= line_s;
    end

    assign line_fall = line_prev & ~line_s;
    assign half_hit  = (cnt_q == HALF_END);
    assign full_hit  = (cnt_q == FULL_END);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (line_fall) state_d = RX_START;
            RX_START: if (half_hit)  state_d = line_s ? RX_IDLE : RX_RECV;
            RX_RECV:  if (full_hit && (bit_q == STOP_IDX)) state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge os_clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // counters, shifter and strobes
    always_ff @(posedge os_clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            bit_q      <= '0;
            shift_q    <= '0;
            valid_strb <= 1'b0;
            err_strb   <= 1'b0;
        end else begin
            valid_strb <= 1'b0;
            err_strb   <= 1'b0;
            unique case (state_q)
                RX_IDLE: begin
                    cnt_q <= '0;
                    bit_q <= '0;
                end
                RX_START: begin
                    cnt_q <= half_hit ? '0 : cnt_q + 1'b1;
                    bit_q <= '0;
                end
                RX_RECV: begin
                    if (full_hit) begin
                        cnt_q <= '0;
                        bit_q <= bit_q + 1'b1;
                        if (bit_q == STOP_IDX) begin
                            valid_strb <= line_s;
                            err_strb   <= ~line_s;
                        end else begin
                            shift_q <= {line_s, shift_q[DATA_W-1:1]};
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    cnt_q <= '0;
                    bit_q <= '0;
                end
            endcase
        end
    end

    assign rx_idle = (state_q == RX_IDLE);
endmodule

// File: rtl/flag_xfer.sv
module flag_xfer #(
    parameter int DATA_W = 8,
    parameter int SYNC_N = 2
) (
    input  logic              cpu_clk,
    input  logic              rst_n,
    input  logic              valid_strb,
    input  logic              err_strb,
    input  logic [DATA_W-1:0] shift_q,
    input  logic              rd_buf,
    input  logic              rd_stat,
    output logic [DATA_W-1:0] rx_byte,
    output logic              buf_full,
    output logic              frame_err,
    output logic              val_fall,
    output logic              err_fall
);
    localparam int NSTRB = 2;

    logic [NSTRB-1:0] strb_in, strb_s, strb_d, strb_fall;

    assign strb_in = {err_strb, valid_strb};

    generate
        for (genvar i = 0; i < NSTRB; i++) begin : g_strb
            rx_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_sync (
                .clk   (cpu_clk),
                .rst_n (rst_n),
                .d     (strb_in[i]),
                .q     (strb_s[i])
            );
        end
    endgenerate

    always_ff @(posedge cpu_clk or negedge rst_n) begin
        if (!rst_n) strb_d <= '0;
        else        strb_d <= strb_s;
    end

    assign strb_fall = strb_d & ~strb_s;
    assign val_fall  = strb_fall[0];
    assign err_fall  = strb_fall[1];

    always_ff @(posedge cpu_clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_byte   <= '0;
            buf_full  <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            if (val_fall) begin
                rx_byte  <= shift_q;
                buf_full <= 1'b1;
            end else if (rd_buf) begin
                buf_full <= 1'b0;
            end
            if (err_fall)     frame_err <= 1'b1;
            else if (rd_stat) frame_err <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rx_sticky.sv
module uart_rx_sticky #(
    parameter int DATA_W = 8,
    parameter int OSR    = 16,
    parameter int SYNC_N = 2
) (
    input  logic              cpu_clk,
    input  logic              os_clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              rd_buf,
    input  logic              rd_stat,
    output logic [DATA_W-1:0] rx_byte,
    output logic              buf_full,
    output logic              frame_err,
    output logic              rx_idle
);
    logic [DATA_W-1:0] shift_q;
    logic              valid_strb, err_strb;
    logic              val_fall, err_fall;

    rx_engine #(.DATA_W(DATA_W), .OSR(OSR), .SYNC_N(SYNC_N)) u_eng (
        .os_clk     (os_clk),
        .rst_n      (rst_n),
        .rx_line    (rx_line),
        .shift_q    (shift_q),
        .valid_strb (valid_strb),
        .err_strb   (err_strb),
        .rx_idle    (rx_idle)
    );

    flag_xfer #(.DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_xfer (
        .cpu_clk    (cpu_clk),
        .rst_n      (rst_n),
        .valid_strb (valid_strb),
        .err_strb   (err_strb),
        .shift_q    (shift_q),
        .rd_buf     (rd_buf),
        .rd_stat    (rd_stat),
        .rx_byte    (rx_byte),
        .buf_full   (buf_full),
        .frame_err  (frame_err),
        .val_fall   (val_fall),
        .err_fall   (err_fall)
    );
endmodule

// File: rtl/rx_sticky_chk.sv
module rx_sticky_chk #(
    parameter int DATA_W = 8
) (
    input logic              cpu_clk,
    input logic              os_clk,
    input logic              rst_n,
    input logic              rd_buf,
    input logic              rd_stat,
    input logic [DATA_W-1:0] rx_byte,
    input logic              buf_full,
    input logic              frame_err,
    input logic              rx_idle,
    input logic              val_fall,
    input logic              err_fall,
    input logic              valid_strb,
    input logic              err_strb
);
    AST_FULL_STICKY: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        buf_full && !rd_buf |=> buf_full); // R7
    AST_FULL_CLEAR: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        rd_buf && !val_fall |=> !buf_full); // R7
    AST_ERR_STICKY: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        frame_err && !rd_stat |=> frame_err); // R8
    AST_ERR_CLEAR: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        rd_stat && !err_fall |=> !frame_err); // R8
    AST_SET_WINS: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        val_fall |=> buf_full); // R9
    AST_ERR_SET: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        err_fall |=> frame_err); // R6
    AST_BYTE_ONLY_GOOD: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        !$stable(rx_byte) |-> buf_full); // R6
    AST_STROBE_EXCL: assert property (@(posedge os_clk) disable iff (!rst_n)
        !(valid_strb && err_strb)); // R6
    AST_IDLE_AFTER_STOP: assert property (@(posedge os_clk) disable iff (!rst_n)
        (valid_strb || err_strb) |-> rx_idle); // R11
endmodule

bind uart_rx_sticky rx_sticky_chk #(.DATA_W(DATA_W)) u_chk (
    .cpu_clk    (cpu_clk),
    .os_clk     (os_clk),
    .rst_n      (rst_n),
    .rd_buf     (rd_buf),
    .rd_stat    (rd_stat),
    .rx_byte    (rx_byte),
    .buf_full   (buf_full),
    .frame_err  (frame_err),
    .rx_idle    (rx_idle),
    .val_fall   (val_fall),
    .err_fall   (err_fall),
    .valid_strb (valid_strb),
    .err_strb   (err_strb)
);

// File: tb/sim_uart_rx_sticky.sv
module sim_uart_rx_sticky;

    typedef struct packed {
        logic [7:0] b;
        logic       err;
        logic [7:0] prev;
    } exp_t;

    logic       cpu_clk = 1'b0;
    logic       os_clk  = 1'b0;
    logic       rst_n   = 1'b0;
    logic       rx_line = 1'b1;
    logic       mon_rd_buf = 1'b0, mon_rd_stat = 1'b0;
    logic       hold_rd_buf = 1'b0, hold_rd_stat = 1'b0;
    logic       rd_buf, rd_stat;
    logic [7:0] rx_byte;
    logic       buf_full, frame_err, rx_idle;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   mon_en  = 1'b0;
    bit   mon_busy = 1'b0;
    bit   done    = 1'b0;
    logic [7:0] last_good = 8'h00;
    exp_t sb_q[$];

    assign rd_buf  = mon_rd_buf  | hold_rd_buf;
    assign rd_stat = mon_rd_stat | hold_rd_stat;

    always #4  cpu_clk = ~cpu_clk;   // 125 MHz
    always #24 os_clk  = ~os_clk;    // oversampling clock

    uart_rx_sticky u0 (
        .cpu_clk   (cpu_clk),
        .os_clk    (os_clk),
        .rst_n     (rst_n),
        .rx_line   (rx_line),
        .rd_buf    (rd_buf),
        .rd_stat   (rd_stat),
        .rx_byte   (rx_byte),
        .buf_full  (buf_full),
        .frame_err (frame_err),
        .rx_idle   (rx_idle)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic os_wait(input int n);
        repeat (n) @(negedge os_clk);
    endtask

    // one 8N1 frame, LSB first, 16 oversampling clocks per bit
    task automatic send_frame(input logic [7:0] b, input logic stop);
        @(negedge os_clk);
        rx_line = 1'b0;
        os_wait(16);
        for (int i = 0; i < 8; i++) begin
            rx_line = b[i];
            os_wait(16);
        end
        rx_line = stop;
        os_wait(16);
        rx_line = 1'b1;
        os_wait(4);
    endtask

    task automatic push_send(input logic [7:0] b, input logic stop);
        exp_t e;
        e.b = b; e.err = ~stop; e.prev = last_good;
        sb_q.push_back(e);
        if (stop) last_good = b;
        send_frame(b, stop);
    endtask

    task automatic drain();
        int t = 0;
        while ((sb_q.size() != 0 || mon_busy) && t < 3000) begin
            @(negedge cpu_clk);
            t++;
        end
        chk("R5 scoreboard drained", sb_q.size(), 0);
    endtask

    // monitor: pops expected items whenever a flag is seen
    initial begin
        exp_t e;
        forever begin
            @(negedge cpu_clk);
            if (mon_en && (buf_full || frame_err)) begin
                mon_busy = 1'b1;
                if (sb_q.size() == 0) begin
                    chk("R5 unexpected flag", {30'd0, frame_err, buf_full}, 32'd0);
                end else begin
                    e = sb_q.pop_front();
                    chk("R11 idle after stop", rx_idle, 1'b1);
                    if (!e.err) begin
                        chk("R5 full set", buf_full, 1'b1);
                        chk("R5 no err", frame_err, 1'b0);
                        chk("R4 byte", rx_byte, e.b);
                        mon_rd_stat = 1'b1; @(negedge cpu_clk); mon_rd_stat = 1'b0;
                        @(negedge cpu_clk);
                        chk("R7 rd_stat keeps full", buf_full, 1'b1);
                        mon_rd_buf = 1'b1; @(negedge cpu_clk); mon_rd_buf = 1'b0;
                        @(negedge cpu_clk);
                        chk("R7 rd_buf clears full", buf_full, 1'b0);
                    end else begin
                        chk("R6 err set", frame_err, 1'b1);
                        chk("R6 full untouched", buf_full, 1'b0);
                        chk("R6 byte kept", rx_byte, e.prev);
                        mon_rd_buf = 1'b1; @(negedge cpu_clk); mon_rd_buf = 1'b0;
                        @(negedge cpu_clk);
                        chk("R8 rd_buf keeps err", frame_err, 1'b1);
                        mon_rd_stat = 1'b1; @(negedge cpu_clk); mon_rd_stat = 1'b0;
                        @(negedge cpu_clk);
                        chk("R8 rd_stat clears err", frame_err, 1'b0);
                    end
                end
                mon_busy = 1'b0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(negedge cpu_clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int cnt;
        repeat (10) @(negedge cpu_clk);
        rst_n = 1'b1;
        os_wait(4);
        @(negedge cpu_clk);
        chk("R1 idle", rx_idle, 1'b1);
        chk("R1 full", buf_full, 1'b0);
        chk("R1 err", frame_err, 1'b0);
        chk("R1 byte", rx_byte, 8'h00);

        // ordinary frames through the scoreboard (R4, R5)
        mon_en = 1'b1;
        push_send(8'hA5, 1'b1);
        push_send(8'h00, 1'b1);
        push_send(8'hFF, 1'b1);
        push_send(8'h3C, 1'b1);
        drain();

        // bad stop, then recovery (R6, R8)
        push_send(8'h5A, 1'b0);
        os_wait(8);
        push_send(8'h81, 1'b1);
        drain();

        // false start (R2, R3)
        @(negedge os_clk);
        rx_line = 1'b0;
        os_wait(5);
        @(negedge cpu_clk);
        chk("R2 idle low in start", rx_idle, 1'b0);
        @(negedge os_clk);
        rx_line = 1'b1;
        os_wait(30);
        @(negedge cpu_clk);
        chk("R3 back to idle", rx_idle, 1'b1);
        chk("R3 no flags", {30'd0, frame_err, buf_full}, 32'd0);

        // overwrite while full (R10)
        mon_en = 1'b0;
        send_frame(8'h12, 1'b1);
        send_frame(8'h34, 1'b1);
        os_wait(4);
        @(negedge cpu_clk);
        chk("R10 full stays", buf_full, 1'b1);
        chk("R10 byte overwritten", rx_byte, 8'h34);
        hold_rd_buf = 1'b1; @(negedge cpu_clk); hold_rd_buf = 1'b0;
        @(negedge cpu_clk);
        chk("R7 full cleared", buf_full, 1'b0);
        last_good = 8'h34;

        // set and clear in the same cycle (R9)
        hold_rd_buf = 1'b1;
        cnt = 0;
        fork
            send_frame(8'hC3, 1'b1);
            begin
                repeat (1150) begin
                    @(negedge cpu_clk);
                    if (buf_full) cnt++;
                end
            end
        join
        hold_rd_buf = 1'b0;
        chk("R9 full visible one cycle", cnt, 1);
        chk("R9 byte loaded", rx_byte, 8'hC3);

        hold_rd_stat = 1'b1;
        cnt = 0;
        fork
            send_frame(8'h66, 1'b0);
            begin
                repeat (1150) begin
                    @(negedge cpu_clk);
                    if (frame_err) cnt++;
                end
            end
        join
        hold_rd_stat = 1'b0;
        chk("R9 err visible one cycle", cnt, 1);
        chk("R6 byte kept on err", rx_byte, 8'hC3);

        os_wait(4);
        finish_run();
    end
endmodule